// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked request port and an external asynchronous static RAM with a 16-bit data bus made of two byte lanes. A requester hands over one access at a time (write or read, address, write data and a two-bit lane mask) through a valid/ready handshake. The controller then drives the memory's address, chip select, output enable, write strobe, the two lane selects and a split data bus with a drive-enable for the pad. Read results come back with a one-cycle valid pulse.

All memory-side pins are registered, so none of them glitches. Each analog timing minimum of the memory is a nanosecond parameter. At elaboration it is rounded up to a whole number of clock cycles, using the clock period parameter. A write is framed so that the write strobe is the signal that ends it: data, address, chip select and lane selects are all held one cycle past its rising edge. After every read, a turnaround window keeps the controller off the bus until the memory has stopped driving it.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1. `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are all 1. `mem_dq_oe` and `rsp_valid` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the controller is idle, and chip select is high whenever `req_ready` is 1.
- R3: A read with a non-zero mask holds chip select, output enable and the selected lane strobes low for exactly RD cycles. It captures `mem_dq_in` at the edge that ends the last of those cycles, and pulses `rsp_valid` in the following cycle, RD+1 cycles after acceptance. RD = max(2, ceil(max(T_RC_NS, T_AA_NS, T_DOE_NS)/CLK_PERIOD_NS)).
- R4: Mask bit 0 selects the low lane (data bits 7:0, strobe `mem_lb_n`). Mask bit 1 selects the high lane (bits 15:8, strobe `mem_ub_n`). A lane whose bit is 0 keeps its strobe high for the whole access, is not written, and reads back as 0x00.
- R5: A write with a non-zero mask first spends one setup cycle with chip select and the selected strobes low, the write strobe high and the data driven. The write strobe is then low for exactly WP cycles, with WP = max(1, ceil(max(T_PWE_NS, T_SD_NS, T_BW_NS)/CLK_PERIOD_NS)). The write strobe is low only while chip select and at least one lane strobe are low.
- R6: A write ends with the write strobe rising while address, data drive, chip select and lane strobes are held for REC = max(1, ceil(T_WC_NS/CLK_PERIOD_NS) - 1 - WP) more cycles. `req_ready` returns 2+WP+REC cycles after acceptance.
- R7: Output enable is high in every cycle where the write strobe is low. The data drive-enable is never 1 while output enable is low.
- R8: After output enable rises, the data drive-enable stays 0 for at least HZ = max(1, ceil(T_HZOE_NS/CLK_PERIOD_NS)) cycles. A write taken right after a read turns its drive on exactly HZ+1 cycles after output enable rose.
- R9: A request with mask 00 causes no strobe activity at all. Such a write returns `req_ready` in the next cycle. Such a read pulses `rsp_valid` with data 0x0000 in the cycle right after acceptance.
- R10: `mem_addr` does not change in any cycle where chip select was already low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low lane, bit 1 high lane |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | High lane strobe, active low |
| mem_lb_n | output | 1 | Low lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive-enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The assertions watch the bus-safety rules in every cycle:
- the write strobe is low only under chip select and a lane strobe, and output enable is high while it is low;
- the drive-enable is never on while output enable is low, and is kept off for the turnaround window;
- the address is frozen while chip select stays low, and address, data and selects are held as the write strobe rises;
- chip select is high whenever the controller is ready.

Only the bench's scenarios can show that the right data reaches the right lane and that cycle counts are exact. Its memory model returns garbage until the read access time has elapsed and checks the write-pulse width. It also confirms that a masked lane is neither written nor returned, and that a zero mask leaves the pins untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int DW    = 16;
    localparam int NLANE = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_WAIT,
        ST_RD_SAMPLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURN
    } st_e;

    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int RD_CYC  = 2,
    parameter int WP_CYC  = 1,
    parameter int REC_CYC = 1,
    parameter int HZ_CYC  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    input  logic [NLANE-1:0]     req_mask,
    output logic                 req_ready,
    output st_e                  nxt_st,
    output logic [AW-1:0]        nxt_addr,
    output logic [DW-1:0]        nxt_wdata,
    output logic [NLANE-1:0]     nxt_mask,
    output logic                 cap_en,
    output logic                 zero_rd
);

    localparam int CMAX = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, HZ_CYC));
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        st_e              st;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [NLANE-1:0] mask;
    } seq_t;

    seq_t r_d, r_q;
    logic accept;

    always_comb begin
        r_d     = r_q;
        accept  = (r_q.st == ST_IDLE) && req_valid;
        zero_rd = accept && !req_write && (req_mask == '0);
        cap_en  = (r_q.st == ST_RD_SAMPLE);
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mask  = req_mask;
                    if (req_mask != '0)
                        r_d.st = req_write ? ST_WR_SETUP : ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: begin
                if (RD_CYC > 2) begin
                    r_d.st  = ST_RD_WAIT;
                    r_d.cnt = CW'(RD_CYC - 3);
                end else begin
                    r_d.st = ST_RD_SAMPLE;
                end
            end
            ST_RD_WAIT: begin
                if (r_q.cnt == '0) r_d.st = ST_RD_SAMPLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_RD_SAMPLE: begin
                r_d.st  = ST_TURN;
                r_d.cnt = CW'(HZ_CYC - 1);
            end
            ST_TURN: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_WR_SETUP: begin
                r_d.st  = ST_WR_PULSE;
                r_d.cnt = CW'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_WR_RECOVER;
                    r_d.cnt = CW'(REC_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WR_RECOVER: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.mask  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign nxt_st    = r_d.st;
    assign nxt_addr  = r_d.addr;
    assign nxt_wdata = r_d.wdata;
    assign nxt_mask  = r_d.mask;

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  st_e              nxt_st,
    input  logic [AW-1:0]    nxt_addr,
    input  logic [DW-1:0]    nxt_wdata,
    input  logic [NLANE-1:0] nxt_mask,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_ub_n,
    output logic             mem_lb_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic [NLANE-1:0] be_n;
        logic [DW-1:0] dq;
        logic          dq_oe;
    } pin_t;

    pin_t p_d, p_q;
    logic is_rd, is_wr;

    always_comb begin
        is_rd = (nxt_st == ST_RD_ADDR) || (nxt_st == ST_RD_WAIT) || (nxt_st == ST_RD_SAMPLE);
        is_wr = (nxt_st == ST_WR_SETUP) || (nxt_st == ST_WR_PULSE) || (nxt_st == ST_WR_RECOVER);
        p_d       = p_q;
        p_d.ce_n  = 1'b1;
        p_d.oe_n  = 1'b1;
        p_d.we_n  = 1'b1;
        p_d.be_n  = '1;
        p_d.dq_oe = 1'b0;
        if (is_rd || is_wr) begin
            p_d.addr = nxt_addr;
            p_d.ce_n = 1'b0;
            p_d.be_n = ~nxt_mask;
        end
        if (is_rd) p_d.oe_n = 1'b0;
        if (is_wr) begin
            p_d.dq    = nxt_wdata;
            p_d.dq_oe = 1'b1;
            p_d.we_n  = (nxt_st != ST_WR_PULSE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.addr  <= '0;
            p_q.ce_n  <= 1'b1;
            p_q.oe_n  <= 1'b1;
            p_q.we_n  <= 1'b1;
            p_q.be_n  <= '1;
            p_q.dq    <= '0;
            p_q.dq_oe <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign mem_addr   = p_q.addr;
    assign mem_ce_n   = p_q.ce_n;
    assign mem_oe_n   = p_q.oe_n;
    assign mem_we_n   = p_q.we_n;
    assign mem_lb_n   = p_q.be_n[0];
    assign mem_ub_n   = p_q.be_n[1];
    assign mem_dq_out = p_q.dq;
    assign mem_dq_oe  = p_q.dq_oe;

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap
    import sram_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             zero_rd,
    input  logic [NLANE-1:0] lane_mask,
    input  logic [DW-1:0]    mem_dq_in,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = cap_en || zero_rd;
        if (zero_rd) c_d.data = '0;
        if (cap_en) begin
            for (int i = 0; i < NLANE; i++)
                c_d.data[i*8 +: 8] = lane_mask[i] ? mem_dq_in[i*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.vld  <= 1'b0;
            c_q.data <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid = c_q.vld;
    assign rsp_rdata = c_q.data;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW            = 18,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 12,
    parameter int T_AA_NS       = 12,
    parameter int T_DOE_NS      = 6,
    parameter int T_WC_NS       = 12,
    parameter int T_PWE_NS      = 8,
    parameter int T_SD_NS       = 6,
    parameter int T_BW_NS       = 8,
    parameter int T_HZOE_NS     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_mask,
    output logic          rsp_valid,
    output logic [15:0]   rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [15:0]   mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_in
);

    localparam int RD_CYC  = imax(2, ns2cyc(imax(T_RC_NS, imax(T_AA_NS, T_DOE_NS)), CLK_PERIOD_NS));
    localparam int WP_CYC  = imax(1, ns2cyc(imax(T_PWE_NS, imax(T_SD_NS, T_BW_NS)), CLK_PERIOD_NS));
    localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int REC_CYC = imax(1, WC_CYC - 1 - WP_CYC);
    localparam int HZ_CYC  = imax(1, ns2cyc(T_HZOE_NS, CLK_PERIOD_NS));

    st_e              nxt_st;
    logic [AW-1:0]    nxt_addr;
    logic [DW-1:0]    nxt_wdata;
    logic [NLANE-1:0] nxt_mask;
    logic             cap_en;
    logic             zero_rd;

    sram_ctrl_seq #(
        .AW(AW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .HZ_CYC(HZ_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
        .nxt_st(nxt_st), .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata), .nxt_mask(nxt_mask),
        .cap_en(cap_en), .zero_rd(zero_rd)
    );

    sram_ctrl_pins #(.AW(AW)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .nxt_st(nxt_st), .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata), .nxt_mask(nxt_mask),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );

    sram_ctrl_rdcap u_rdcap (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .zero_rd(zero_rd), .lane_mask(nxt_mask), .mem_dq_in(mem_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int AW     = 18,
    parameter int HZ_CYC = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic          mem_dq_oe
);

    localparam int SW = $clog2(HZ_CYC + 2);

    logic [SW-1:0] since_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_oe_q <= SW'(HZ_CYC + 1);
        else if (!mem_oe_n)
            since_oe_q <= '0;
        else if (since_oe_q < SW'(HZ_CYC + 1))
            since_oe_q <= since_oe_q + 1'b1;
    end

    p_idle_ce_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    p_we_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && (!mem_ub_n || !mem_lb_n)));

    p_we_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)));

    p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_oe_q >= SW'(HZ_CYC)));

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .HZ_CYC(HZ_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

    localparam int AW   = 4;
    localparam int PER  = 8;
    localparam int TAA  = 20;
    localparam int TPWE = 12;
    localparam int TWC  = 30;
    localparam int THZ  = 10;
    // expected cycle counts from the requirement formulas (other minima: 12, 6, 6, 8 ns)
    localparam int E_RD  = 3;  // max(2, ceil(max(12,20,6)/8))
    localparam int E_WP  = 2;  // ceil(max(12,6,8)/8)
    localparam int E_REC = 1;  // max(1, ceil(30/8) - 1 - 2)
    localparam int E_HZ  = 2;  // ceil(10/8)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0]   mem_dq_out, mem_dq_in;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sram_ctrl #(
        .AW(AW), .CLK_PERIOD_NS(PER), .T_AA_NS(TAA), .T_PWE_NS(TPWE),
        .T_WC_NS(TWC), .T_HZOE_NS(THZ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model and pin monitors
    logic [15:0] mem [16];
    logic [15:0] shadow [16];
    int  rd_cnt = 0, wl_cnt = 0, strobe_cnt = 0, cyc = 0, t_oe = 0, last_gap = 0;
    int  contention = 0, addr_moves = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_oe_en = 1'b0, prev_ce = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    assign mem_dq_in = (rd_cnt >= E_RD && mem_we_n) ?
        {(mem_ub_n ? 8'hC3 : mem[mem_addr][15:8]), (mem_lb_n ? 8'hC3 : mem[mem_addr][7:0])} :
        16'hC3C3;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_ce_n || !mem_oe_n || !mem_we_n || !mem_ub_n || !mem_lb_n || mem_dq_oe)
                strobe_cnt++;
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!mem_we_n && !mem_oe_n) contention++;
            if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) addr_moves++;
            rd_cnt = (!mem_ce_n && !mem_oe_n) ? rd_cnt + 1 : 0;
            if (!mem_we_n) wl_cnt++;
            if (mem_we_n && !prev_we) begin
                chk(wl_cnt == E_WP, "R5 write pulse width", wl_cnt, E_WP);
                chk(!mem_ce_n && mem_dq_oe, "R6 hold at write end", {mem_ce_n, mem_dq_oe}, 2'b01);
                if (!mem_lb_n) mem[mem_addr][7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) mem[mem_addr][15:8] = mem_dq_out[15:8];
                wl_cnt = 0;
            end
            if (mem_oe_n && !prev_oe) t_oe = cyc;
            if (mem_dq_oe && !prev_oe_en) last_gap = cyc - t_oe;
            prev_we = mem_we_n; prev_oe = mem_oe_n; prev_oe_en = mem_dq_oe;
            prev_ce = mem_ce_n; prev_addr = mem_addr;
        end
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
        int k;
        issue(1'b1, a, d, m);
        if (m != 2'b00) chk(!req_ready, "R2 busy during write", req_ready, 0);
        k = 1;
        while (!req_ready && k < 50) begin @(negedge clk); k++; end
        if (m == 2'b00) chk(k == 1, "R9 zero-mask write latency", k, 1);
        else            chk(k == 2 + E_WP + E_REC, "R6 write cycles", k, 2 + E_WP + E_REC);
        if (m[0]) shadow[a][7:0]  = d[7:0];
        if (m[1]) shadow[a][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input string req);
        int k;
        logic [15:0] e;
        issue(1'b0, a, 16'h0, m);
        k = 1;
        while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
        e = {(m[1] ? shadow[a][15:8] : 8'h00), (m[0] ? shadow[a][7:0] : 8'h00)};
        chk(rsp_rdata == e, req, rsp_rdata, e);
        if (m == 2'b00) chk(k == 1, "R9 zero-mask read latency", k, 1);
        else            chk(k == E_RD + 1, "R3 read latency", k, E_RD + 1);
    endtask

    initial begin
        int s0;
        for (int i = 0; i < 16; i++) begin mem[i] = 16'h0; shadow[i] = 16'h0; end
        repeat (4) @(negedge clk);
        // R1 reset state (still in reset, after several edges)
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n &&
            !mem_dq_oe && !rsp_valid, "R1 reset state",
            {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rsp_valid},
            8'b11111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", req_ready, 1);

        // full-width writes and reads over every address (R3, R5, R6)
        for (int a = 0; a < 16; a++) do_write(AW'(a), 16'(a * 16'h0931 + 16'h1234), 2'b11);
        for (int a = 0; a < 16; a++) do_read(AW'(a), 2'b11, "R3 full read data");

        // single-lane writes, then full reads (R4)
        for (int a = 0; a < 16; a++)
            do_write(AW'(a), 16'(~(a * 16'h0931)), (a % 2 == 0) ? 2'b01 : 2'b10);
        for (int a = 0; a < 16; a++) do_read(AW'(a), 2'b11, "R4 lane-masked write");

        // single-lane reads return zero in the disabled lane (R4)
        for (int a = 0; a < 4; a++) begin
            do_read(AW'(a), 2'b01, "R4 low-lane read");
            do_read(AW'(a), 2'b10, "R4 high-lane read");
        end

        // zero mask: no pin activity (R9)
        s0 = strobe_cnt;
        do_write(AW'(3), 16'hFFFF, 2'b00);
        do_read(AW'(3), 2'b00, "R9 zero-mask read data");
        chk(strobe_cnt == s0, "R9 no strobe activity", strobe_cnt - s0, 0);
        do_read(AW'(3), 2'b11, "R9 memory unchanged");

        // read followed at once by write: turnaround gap (R8)
        do_read(AW'(5), 2'b11, "R3 read before write");
        do_write(AW'(5), 16'hBEEF, 2'b11);
        chk(last_gap == E_HZ + 1, "R8 turnaround gap", last_gap, E_HZ + 1);
        do_read(AW'(5), 2'b11, "R3 read after turnaround");

        repeat (3) @(negedge clk);
        chk(contention == 0, "R7 bus contention", contention, 0);
        chk(addr_moves == 0, "R10 address stable under chip select", addr_moves, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule